// File: doc/BRIEF.md
# Interrupt Controller Register Port

This block is the byte-wide register port of an eight-line priority interrupt controller. A single address bit selects one of two ports. Writes to port 0 are told apart by two data bits. They can start an initialization sequence, carry a mode command (poll, register read select, special mask), or carry a priority command (end-of-interrupt in its forms, priority set, rotate-on-auto-EOI). Writes to port 1 either load the line mask or supply the next word of the initialization sequence. The path through that sequence depends on the single-mode and fourth-word flags captured at its start.

Reads return the request register, the in-service register or the mask. When a poll is pending, a read instead returns the line that the priority core reports as winning. It also tells the core to clear that line's request and in-service bits. The priority evaluation itself sits in a separate core. This block passes that core its configuration as held levels and its commands as single-cycle strobes.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset, mask_out, vec_base, rdata and every flag and strobe output are 0. The read select points at the request register, and the port expects an ordinary mask write on port 1.
- R2: A port-0 write with data bit 4 set raises init_stb for one cycle. It clears the mask, vector base, auto-EOI, nested, special-mask, poll, read-select and rotate-on-auto-EOI state. It captures data bit 0 as the fourth-word flag and data bit 1 as the single flag, and makes the next port-1 write the vector-base word.
- R3: A port-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set makes poll_pend 1. Bit 1 set loads the read select from bit 0 (1 = in-service, 0 = request), shown on rd_svc. Bit 6 set loads spec_mask from bit 5. Any bit that is clear leaves its field unchanged.
- R4: A port-0 write with bits 4 and 3 clear decodes bits 7:5 as a command. Code 0 clears rot_aeoi and code 4 sets it. Codes 1 and 5 pulse eoi_stb with eoi_spec=0 and eoi_line=0, with eoi_rot=1 for code 5. Codes 3 and 7 pulse eoi_stb with eoi_spec=1 and eoi_line=data bits 2:0, with eoi_rot=1 for code 7. Code 6 pulses prio_stb with prio_line=data bits 2:0. Code 2 changes nothing.
- R5: The vector-base word stores data bits 7:3, shown as vec_base = {bits 7:3, 3'b000}.
- R6: After the vector-base word, the sequence goes to the cascade word, or to the mode word if single and the fourth-word flag is set, or to normal operation if single without the fourth-word flag. After the cascade word it goes to the mode word if the fourth-word flag is set, else to normal operation. After the mode word it goes to normal operation.
- R7: The mode word loads nested from data bit 4 and auto_eoi from data bit 1.
- R8: In normal operation a port-1 write loads mask_out with the data.
- R9: A read with poll_pend set returns {5'b0, poll_ln} and pulses poll_clr_stb with poll_clr_line = poll_ln when poll_vld is 1. When poll_vld is 0 it returns 8'h07 with no pulse. Either way poll_pend clears.
- R10: A read without a pending poll returns mask_out at port 1, and at port 0 returns svc_in if the read select is in-service, otherwise req_in.
- R11: Every command result appears the cycle after the write or read. Strobes last exactly one cycle, and all strobes are 0 in a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Port select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe (ignored while wr is high) |
| wdata | input | 8 | Write data |
| req_in | input | 8 | Request register from the core |
| svc_in | input | 8 | In-service register from the core |
| poll_vld | input | 1 | Core has a winning line |
| poll_ln | input | 3 | Winning line from the core |
| rdata | output | 8 | Read data, registered |
| mask_out | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, low 3 bits zero |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| nested | output | 1 | Fully nested mode |
| spec_mask | output | 1 | Special mask mode |
| rd_svc | output | 1 | Read select: 1 = in-service |
| poll_pend | output | 1 | Poll armed for next read |
| rot_aeoi | output | 1 | Rotate on auto-EOI |
| init_stb | output | 1 | Initialization started; core drops its output |
| eoi_stb | output | 1 | End-of-interrupt command |
| eoi_spec | output | 1 | EOI names a line |
| eoi_rot | output | 1 | EOI also rotates priority |
| eoi_line | output | 3 | Line for specific EOI |
| prio_stb | output | 1 | Set-priority command |
| prio_line | output | 3 | Lowest-priority line for set-priority |
| poll_clr_stb | output | 1 | Clear request and in-service of a polled line |
| poll_clr_line | output | 3 | Line to clear |

## Verification
Every result of a write or read is registered once, so each output is due on the first clock edge after the access. The bench drives an access on a falling edge and samples all outputs 1 ns after the next rising edge. It compares them there with values its own model computed from the same access. The bench then idles for one cycle and samples again, to confirm that every strobe has dropped and that held fields are unchanged. The core inputs are randomized with each access, so a read proves it used the values present in its own cycle.

// File: rtl/pic_cmd_port.sv
module pic_cmd_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  logic [7:0] req_in,
  input  logic [7:0] svc_in,
  input  logic       poll_vld,
  input  logic [2:0] poll_ln,
  output logic [7:0] rdata,
  output logic [7:0] mask_out,
  output logic [7:0] vec_base,
  output logic       auto_eoi,
  output logic       nested,
  output logic       spec_mask,
  output logic       rd_svc,
  output logic       poll_pend,
  output logic       rot_aeoi,
  output logic       init_stb,
  output logic       eoi_stb,
  output logic       eoi_spec,
  output logic       eoi_rot,
  output logic [2:0] eoi_line,
  output logic       prio_stb,
  output logic [2:0] prio_line,
  output logic       poll_clr_stb,
  output logic [2:0] poll_clr_line
);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_BASE = 2'd1, ST_CASC = 2'd2, ST_MODE = 2'd3} step_t;

  step_t      step;
  logic       four_q, single_q;
  logic [4:0] base_q;

  wire wr0      = wr & ~addr;
  wire is_init  = wr0 & wdata[4];
  wire is_mode  = wr0 & ~wdata[4] & wdata[3];
  wire is_cmd   = wr0 & ~wdata[4] & ~wdata[3];
  wire is_data  = wr & addr;
  wire is_read  = rd & ~wr;
  wire [2:0] op = wdata[7:5];

  step_t after_base;
  always_comb begin
    if (!single_q)   after_base = ST_CASC;
    else if (four_q) after_base = ST_MODE;
    else             after_base = ST_RUN;
  end

  assign vec_base = {base_q, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step          <= ST_RUN;
      four_q        <= 1'b0;
      single_q      <= 1'b0;
      base_q        <= '0;
      mask_out      <= '0;
      auto_eoi      <= 1'b0;
      nested        <= 1'b0;
      spec_mask     <= 1'b0;
      rd_svc        <= 1'b0;
      poll_pend     <= 1'b0;
      rot_aeoi      <= 1'b0;
      rdata         <= '0;
      init_stb      <= 1'b0;
      eoi_stb       <= 1'b0;
      eoi_spec      <= 1'b0;
      eoi_rot       <= 1'b0;
      eoi_line      <= '0;
      prio_stb      <= 1'b0;
      prio_line     <= '0;
      poll_clr_stb  <= 1'b0;
      poll_clr_line <= '0;
    end else begin
      init_stb     <= 1'b0;
      eoi_stb      <= 1'b0;
      prio_stb     <= 1'b0;
      poll_clr_stb <= 1'b0;
      if (is_init) begin
        init_stb  <= 1'b1;
        mask_out  <= '0;
        base_q    <= '0;
        auto_eoi  <= 1'b0;
        nested    <= 1'b0;
        spec_mask <= 1'b0;
        rd_svc    <= 1'b0;
        poll_pend <= 1'b0;
        rot_aeoi  <= 1'b0;
        four_q    <= wdata[0];
        single_q  <= wdata[1];
        step      <= ST_BASE;
      end else if (is_mode) begin
        if (wdata[2]) poll_pend <= 1'b1;
        if (wdata[1]) rd_svc    <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end else if (is_cmd) begin
        case (op)
          3'd0: rot_aeoi <= 1'b0;
          3'd4: rot_aeoi <= 1'b1;
          3'd1, 3'd5: begin
            eoi_stb  <= 1'b1;
            eoi_spec <= 1'b0;
            eoi_rot  <= op[2];
            eoi_line <= 3'd0;
          end
          3'd3, 3'd7: begin
            eoi_stb  <= 1'b1;
            eoi_spec <= 1'b1;
            eoi_rot  <= op[2];
            eoi_line <= wdata[2:0];
          end
          3'd6: begin
            prio_stb  <= 1'b1;
            prio_line <= wdata[2:0];
          end
          default: ;
        endcase
      end else if (is_data) begin
        case (step)
          ST_RUN:  mask_out <= wdata;
          ST_BASE: begin
            base_q <= wdata[7:3];
            step   <= after_base;
          end
          ST_CASC: step <= four_q ? ST_MODE : ST_RUN;
          ST_MODE: begin
            nested   <= wdata[4];
            auto_eoi <= wdata[1];
            step     <= ST_RUN;
          end
          default: step <= ST_RUN;
        endcase
      end else if (is_read) begin
        if (poll_pend) begin
          poll_pend     <= 1'b0;
          rdata         <= poll_vld ? {5'b0, poll_ln} : 8'h07;
          poll_clr_stb  <= poll_vld;
          poll_clr_line <= poll_ln;
        end else if (addr) begin
          rdata <= mask_out;
        end else begin
          rdata <= rd_svc ? svc_in : req_in;
        end
      end
    end
  end

endmodule

module pic_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr,
  input logic       wr,
  input logic       rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] mask_out,
  input logic       auto_eoi,
  input logic       nested,
  input logic       spec_mask,
  input logic       poll_pend,
  input logic       init_stb,
  input logic       eoi_stb,
  input logic       prio_stb,
  input logic       poll_clr_stb
);

  // R2
  init_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && wdata[4]) |=> (init_stb && mask_out == 8'h00 && !auto_eoi && !nested && !spec_mask && !poll_pend));

  // R4
  eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb |-> $past(wr && !addr && wdata[4:3] == 2'b00 && wdata[5]));

  // R9
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_clr_stb |-> (!poll_pend && $past(rd && !wr && poll_pend)));

  // R10
  mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && addr && !poll_pend) |=> rdata == $past(mask_out));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_stb, eoi_stb, prio_stb, poll_clr_stb}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !rd) |=> !(init_stb || eoi_stb || prio_stb || poll_clr_stb));

endmodule

bind pic_cmd_port pic_cmd_port_chk u_chk (.*);

// File: tb/sim_pic_cmd_port.sv
module sim_pic_cmd_port;
  logic clk = 0, rst_n = 0;
  logic addr = 0, wr = 0, rd = 0;
  logic [7:0] wdata = 0, req_in = 0, svc_in = 0;
  logic poll_vld = 0;
  logic [2:0] poll_ln = 0;
  logic [7:0] rdata, mask_out, vec_base;
  logic auto_eoi, nested, spec_mask, rd_svc, poll_pend, rot_aeoi;
  logic init_stb, eoi_stb, eoi_spec, eoi_rot, prio_stb, poll_clr_stb;
  logic [2:0] eoi_line, prio_line, poll_clr_line;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pic_cmd_port u0 (.*);

  // model state
  logic [7:0] m_mask = 0, m_rdata = 0;
  int m_step = 0;
  bit m_four = 0, m_single = 0, m_aeoi = 0, m_nest = 0, m_smask = 0, m_rsel = 0, m_poll = 0, m_rotae = 0;
  logic [4:0] m_base = 0;
  bit e_init, e_eoi, e_spec, e_rot, e_prio, e_pclr;
  logic [2:0] e_line, e_pline, e_pcline;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input bit a, input bit w, input bit r, input logic [7:0] d,
                       input logic [7:0] rq, input logic [7:0] sv, input bit pv, input logic [2:0] pl);
    e_init = 0; e_eoi = 0; e_prio = 0; e_pclr = 0;
    if (w && !a && d[4]) begin
      e_init = 1; m_mask = 0; m_base = 0; m_aeoi = 0; m_nest = 0; m_smask = 0;
      m_rsel = 0; m_poll = 0; m_rotae = 0; m_four = d[0]; m_single = d[1]; m_step = 1;
    end else if (w && !a && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smask = d[5];
    end else if (w && !a) begin
      case (d[7:5])
        0: m_rotae = 0;
        4: m_rotae = 1;
        1, 5: begin e_eoi = 1; e_spec = 0; e_rot = d[7]; e_line = 0; end
        3, 7: begin e_eoi = 1; e_spec = 1; e_rot = d[7]; e_line = d[2:0]; end
        6: begin e_prio = 1; e_pline = d[2:0]; end
        default: ;
      endcase
    end else if (w) begin
      case (m_step)
        0: m_mask = d;
        1: begin m_base = d[7:3]; m_step = !m_single ? 2 : (m_four ? 3 : 0); end
        2: m_step = m_four ? 3 : 0;
        default: begin m_nest = d[4]; m_aeoi = d[1]; m_step = 0; end
      endcase
    end else if (r) begin
      if (m_poll) begin
        m_poll = 0;
        m_rdata = pv ? {5'b0, pl} : 8'h07;
        e_pclr = pv; e_pcline = pl;
      end else m_rdata = a ? m_mask : (m_rsel ? sv : rq);
    end
  endtask

  task automatic op(input bit a, input bit w, input bit r, input logic [7:0] d,
                    input logic [7:0] rq, input logic [7:0] sv, input bit pv, input logic [2:0] pl);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d; req_in = rq; svc_in = sv; poll_vld = pv; poll_ln = pl;
    model(a, w, r, d, rq, sv, pv, pl);
    @(posedge clk); #1;
    check("R2 init_stb", {15'b0, init_stb}, {15'b0, e_init});
    check("R4 eoi_stb", {15'b0, eoi_stb}, {15'b0, e_eoi});
    if (e_eoi) check("R4 eoi fields", {11'b0, eoi_spec, eoi_rot, eoi_line}, {11'b0, e_spec, e_rot, e_line});
    check("R4 prio_stb", {15'b0, prio_stb}, {15'b0, e_prio});
    if (e_prio) check("R4 prio_line", {13'b0, prio_line}, {13'b0, e_pline});
    check("R4 rot_aeoi", {15'b0, rot_aeoi}, {15'b0, m_rotae});
    check("R3 mode flags", {13'b0, poll_pend, rd_svc, spec_mask}, {13'b0, m_poll, m_rsel, m_smask});
    check("R5 vec_base", {8'b0, vec_base}, {8'b0, m_base, 3'b000});
    check("R7 nested/auto_eoi", {14'b0, nested, auto_eoi}, {14'b0, m_nest, m_aeoi});
    check("R8 mask_out", {8'b0, mask_out}, {8'b0, m_mask});
    check("R9 poll_clr_stb", {15'b0, poll_clr_stb}, {15'b0, e_pclr});
    if (e_pclr) check("R9 poll_clr_line", {13'b0, poll_clr_line}, {13'b0, e_pcline});
    check("R10 rdata", {8'b0, rdata}, {8'b0, m_rdata});
    @(negedge clk); wr = 0; rd = 0;
    @(posedge clk); #1;
    check("R11 strobes idle", {12'b0, init_stb, eoi_stb, prio_stb, poll_clr_stb}, 16'h0);
    check("R11 fields held", {mask_out, vec_base}, {m_mask, m_base, 3'b000});
  endtask

  task automatic wrt(input bit a, input logic [7:0] d);
    op(a, 1, 0, d, $urandom, $urandom, $urandom, $urandom);
  endtask

  task automatic rdp(input bit a, input bit pv, input logic [2:0] pl);
    op(a, 0, 1, 8'h00, $urandom, $urandom, pv, pl);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 reset outputs", {mask_out, vec_base}, 16'h0);
    check("R1 reset flags", {7'b0, auto_eoi, nested, spec_mask, rd_svc, poll_pend, rot_aeoi, init_stb, eoi_stb, prio_stb},
          16'h0);
    check("R1 reset rdata", {8'b0, rdata}, 16'h0);
    @(negedge clk); rst_n = 1;
    wrt(1, 8'h3C);
    check("R1 step run after reset", {8'b0, mask_out}, 16'h003C);

    // R6: all four sequence paths
    for (int k = 0; k < 4; k++) begin
      wrt(0, 8'h10 | 8'(k));
      wrt(1, 8'hA8);
      if (!k[1]) wrt(1, 8'h04);
      if (k[0]) wrt(1, 8'h12);
      wrt(1, 8'h5A);
      check("R6 sequence end", {8'b0, mask_out}, 16'h005A);
      check("R7 mode word", {14'b0, nested, auto_eoi}, k[0] ? 16'h3 : 16'h0);
    end

    // R4: every command code
    for (int c = 0; c < 8; c++) wrt(0, 8'((c << 5) | 5));

    // R3 / R10: read select
    wrt(0, 8'h0B); rdp(0, 0, 0);
    wrt(0, 8'h0A); rdp(0, 0, 0);
    wrt(0, 8'h68); wrt(0, 8'h48);
    rdp(1, 0, 0);

    // R9: poll with and without winner
    wrt(0, 8'h0C); rdp(0, 1, 3'd5);
    wrt(0, 8'h0C); rdp(1, 0, 3'd2);
    rdp(0, 1, 3'd6);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] d = $urandom;
      case (sel)
        0: wrt(0, d | 8'h10);
        1, 2: wrt(0, (d & 8'hE7) | 8'h08);
        3, 4: wrt(0, d & 8'hE7);
        5, 6: wrt(1, d);
        default: rdp($urandom_range(0, 1), $urandom_range(0, 1), $urandom);
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule